// File: doc/BRIEF.md
# Masked Vector Element Write Sequencer

This block walks through the elements of one vector instruction, one element per clock. For each index it decides whether the destination receives the operation result, receives all ones, or stays as it was. A start pulse loads the starting index, the active length, the total element count of the destination group and three policy bits:
- `vmIn` selects unmasked operation.
- `vmaIn` selects all-ones fill for masked-off elements.
- `vtaIn` selects all-ones fill for tail elements.

While the block runs, it shows the current element index on its write port. The same index addresses a 64-bit mask word through a combinational read port, and an external operation unit returns the element result in the same cycle.

Elements below the starting index are never touched. Body elements follow in ascending order. When the tail policy asks for it, the tail comes next, also ascending. A progress output holds the index of the next body element, so an interrupted instruction could resume from it. The progress output returns to zero once the body is finished. If the starting index already reaches the active length, nothing is written and the block finishes at once.

Top module: `velem_wr_seq`

## Requirements
- R1: A start accepted with `vstartIn >= vlIn` writes no element. It raises `done` in the next cycle, and `vstartOut` is 0 in that cycle.
- R2: For a start accepted at a clock edge, the body elements `vstartIn` up to `vlIn-1` appear on `wrIdx` in ascending order, one per cycle, beginning in the cycle after that edge.
- R3: With `vmIn = 1`, every body element is written (`wrEn = 1`) with `opResult`.
- R4: With `vmIn = 0`, the mask bit of element i is bit (i mod 64) of the mask word at address (i div 64). `maskRdAddr` carries that address in the cycle where element i is on `wrIdx`, and an element whose bit is 1 is written with `opResult`.
- R5: With `vmIn = 0`, an element whose mask bit is 0 is written with all ones if `vmaIn = 1`, and is not written (`wrEn = 0`) if `vmaIn = 0`.
- R6: With `vtaIn = 1` and `totalIn > vlIn`, the elements `vlIn` up to `totalIn-1` are written with all ones in ascending order, directly after the last body element. With `vtaIn = 0`, the tail takes no cycles and gets no writes.
- R7: No element below the captured `vstartIn` is ever written.
- R8: `vstartOut` equals the index of the next body element to process during the body. It is 0 from the cycle after the last body element onward, and whenever `done` is high.
- R9: `done` is high for exactly one cycle, in the cycle after the last element visited.
- R10: `busy` is high from the cycle after an accepted start through the `done` cycle. A start pulse while `busy` is high is ignored.
- R11: During reset, `busy`, `done` and `wrEn` are 0 and `vstartOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction (taken only when idle) |
| vstartIn | input | IDX_W | First body element index |
| vlIn | input | IDX_W | Active vector length |
| totalIn | input | IDX_W | Total elements in the destination group |
| vmIn | input | 1 | 1 = unmasked, 0 = use mask |
| vmaIn | input | 1 | Fill masked-off elements with ones |
| vtaIn | input | 1 | Fill tail elements with ones |
| maskRdAddr | output | IDX_W-6 | Mask word address for the current element |
| maskRdData | input | 64 | Mask word returned combinationally |
| opResult | input | DATA_W | Operation result for the element on `wrIdx` |
| wrEn | output | 1 | Destination write strobe |
| wrIdx | output | IDX_W | Current element index |
| wrData | output | DATA_W | Destination write data |
| vstartOut | output | IDX_W | Updated start index |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties check the following on every cycle:
- `done` is a single-cycle pulse.
- An early-exit start leads straight to `done`.
- `busy` holds until `done`.
- The element index steps by exactly one while elements are being visited.
- No write happens outside `busy`.
- `vstartOut` is zero whenever `done` is high.

Other behaviour can only be shown by the bench scenarios, which compare against a behavioural model every clock. These cover the per-element choice between result, all ones and no write under each mask and policy setting, mask lookups that cross a word boundary, tail fill versus tail skip, and a start pulse that arrives mid-sequence.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_TAIL = 2'd2,
    ST_FIN  = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // load parameters and first index
    logic advance;     // step the element index
    logic clearStart;  // force progress register to zero
    logic bodyPhase;   // current element is a body element
    logic tailPhase;   // current element is a tail element
  } seqCtl_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic noBody;   // start index at or beyond length
    logic bodyEnd;  // current element is the last body element
    logic hasTail;  // tail fill requested and tail non-empty
    logic tailEnd;  // current element is the last tail element
  } seqFlg_t;

endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  seqFlg_t flg,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    done
);

  seqState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (flg.noBody) begin
            ctl.clearStart = 1'b1;
            stateNxt       = ST_FIN;
          end else begin
            ctl.capture = 1'b1;
            stateNxt    = ST_BODY;
          end
        end
      end
      ST_BODY: begin
        ctl.advance   = 1'b1;
        ctl.bodyPhase = 1'b1;
        if (flg.bodyEnd) begin
          ctl.clearStart = 1'b1;
          stateNxt       = flg.hasTail ? ST_TAIL : ST_FIN;
        end
      end
      ST_TAIL: begin
        ctl.advance   = 1'b1;
        ctl.tailPhase = 1'b1;
        if (flg.tailEnd) stateNxt = ST_FIN;
      end
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1
  early_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && flg.noBody) |=> done);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

// File: rtl/vseq_dp.sv
module vseq_dp
  import vseq_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int DATA_W = 32,
  parameter int MASK_W = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqCtl_t                 ctl,
  input  logic [IDX_W-1:0]        vstartIn,
  input  logic [IDX_W-1:0]        vlIn,
  input  logic [IDX_W-1:0]        totalIn,
  input  logic                    vmIn,
  input  logic                    vmaIn,
  input  logic                    vtaIn,
  input  logic [MASK_W-1:0]       maskRdData,
  input  logic [DATA_W-1:0]       opResult,
  output seqFlg_t                 flg,
  output logic [IDX_W-$clog2(MASK_W)-1:0] maskRdAddr,
  output logic                    wrEn,
  output logic [IDX_W-1:0]        wrIdx,
  output logic [DATA_W-1:0]       wrData,
  output logic [IDX_W-1:0]        vstartOut
);

  localparam int BIT_SEL_W = $clog2(MASK_W);

  logic [IDX_W-1:0] curIdx, vlR, totalR, vstartR;
  logic             vmR, vmaR, vtaR;
  logic [IDX_W:0]   nextIdx;
  logic             maskBit, active;

  assign nextIdx = {1'b0, curIdx} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx <= '0;
      vlR    <= '0;
      totalR <= '0;
      vmR    <= 1'b0;
      vmaR   <= 1'b0;
      vtaR   <= 1'b0;
    end else if (ctl.capture) begin
      curIdx <= vstartIn;
      vlR    <= vlIn;
      totalR <= totalIn;
      vmR    <= vmIn;
      vmaR   <= vmaIn;
      vtaR   <= vtaIn;
    end else if (ctl.advance) begin
      curIdx <= nextIdx[IDX_W-1:0];
    end
  end

  // progress register: next body element, zero once the body is over
  always_ff @(posedge clk) begin
    if (!rstN)                            vstartR <= '0;
    else if (ctl.capture)                 vstartR <= vstartIn;
    else if (ctl.clearStart)              vstartR <= '0;
    else if (ctl.advance && ctl.bodyPhase) vstartR <= nextIdx[IDX_W-1:0];
  end

  assign flg.noBody  = (vstartIn >= vlIn);
  assign flg.bodyEnd = (nextIdx == {1'b0, vlR});
  assign flg.tailEnd = (nextIdx == {1'b0, totalR});
  assign flg.hasTail = vtaR && (totalR > vlR);

  assign maskRdAddr = curIdx[IDX_W-1:BIT_SEL_W];
  assign maskBit    = maskRdData[curIdx[BIT_SEL_W-1:0]];
  assign active     = vmR | maskBit;

  assign wrIdx     = curIdx;
  assign wrEn      = ctl.tailPhase | (ctl.bodyPhase & (active | vmaR));
  assign wrData    = (ctl.bodyPhase && active) ? opResult : {DATA_W{1'b1}};
  assign vstartOut = vstartR;

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> (curIdx == IDX_W'($past(curIdx) + 1'b1)));

endmodule

// File: rtl/velem_wr_seq.sv
module velem_wr_seq
  import vseq_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int DATA_W = 32,
  parameter int MASK_W = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [IDX_W-1:0]        vstartIn,
  input  logic [IDX_W-1:0]        vlIn,
  input  logic [IDX_W-1:0]        totalIn,
  input  logic                    vmIn,
  input  logic                    vmaIn,
  input  logic                    vtaIn,
  output logic [IDX_W-$clog2(MASK_W)-1:0] maskRdAddr,
  input  logic [MASK_W-1:0]       maskRdData,
  input  logic [DATA_W-1:0]       opResult,
  output logic                    wrEn,
  output logic [IDX_W-1:0]        wrIdx,
  output logic [DATA_W-1:0]       wrData,
  output logic [IDX_W-1:0]        vstartOut,
  output logic                    busy,
  output logic                    done
);

  seqCtl_t ctl;
  seqFlg_t flg;

  vseq_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .flg   (flg),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  vseq_dp #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W),
    .MASK_W (MASK_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .vstartIn   (vstartIn),
    .vlIn       (vlIn),
    .totalIn    (totalIn),
    .vmIn       (vmIn),
    .vmaIn      (vmaIn),
    .vtaIn      (vtaIn),
    .maskRdData (maskRdData),
    .opResult   (opResult),
    .flg        (flg),
    .maskRdAddr (maskRdAddr),
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .wrData     (wrData),
    .vstartOut  (vstartOut)
  );

  // R8
  done_vstart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (vstartOut == '0));

  // R10
  wr_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy);

endmodule

// File: tb/sim_velem_wr_seq.sv
`timescale 1ns/1ps
module sim_velem_wr_seq;

  localparam int IW = 9;
  localparam int DW = 32;
  localparam int AW = IW - 6;
  localparam longint ONES = 64'hFFFF_FFFF;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] vstartIn = '0, vlIn = '0, totalIn = '0;
  logic          vmIn = 1'b0, vmaIn = 1'b0, vtaIn = 1'b0;
  logic [AW-1:0] maskRdAddr;
  logic [63:0]   maskRdData;
  logic [DW-1:0] opResult;
  logic          wrEn, busy, done;
  logic [IW-1:0] wrIdx, vstartOut;
  logic [DW-1:0] wrData;

  logic [63:0] maskMem [0:7];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  function automatic logic [DW-1:0] opFn(int i);
    return 32'hA500_0000 + DW'(i * 7);
  endfunction

  function automatic bit maskOf(int i);
    return maskMem[i / 64][i % 64];
  endfunction

  assign maskRdData = maskMem[maskRdAddr];
  assign opResult   = opFn(int'(wrIdx));

  velem_wr_seq #(.IDX_W(IW), .DATA_W(DW), .MASK_W(64)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .vstartIn(vstartIn), .vlIn(vlIn),
    .totalIn(totalIn), .vmIn(vmIn), .vmaIn(vmaIn), .vtaIn(vtaIn),
    .maskRdAddr(maskRdAddr), .maskRdData(maskRdData), .opResult(opResult),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .vstartOut(vstartOut),
    .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // one cycle of model comparison
  task automatic cmpCycle(string tag, int vs, bit eWr, int eIdx, longint eData,
                          bit eDone, int eVs, bit chkAddr);
    chk(tag, "wrEn", longint'(wrEn), longint'(eWr));
    if (eWr) begin
      chk("R2", "wrIdx", longint'(wrIdx), longint'(eIdx));
      chk(tag, "wrData", longint'(wrData), eData);
    end
    if (wrEn) chk("R7", "wrIdx>=vstart", longint'(int'(wrIdx) >= vs), 1);
    if (chkAddr) chk("R4", "maskRdAddr", longint'(maskRdAddr), longint'(eIdx / 64));
    chk("R9", "done", longint'(done), longint'(eDone));
    chk("R10", "busy", longint'(busy), 1);
    chk("R8", "vstartOut", longint'(vstartOut), longint'(eVs));
  endtask

  task automatic runOp(int vs, int vl, int tot, bit m, bit ma, bit ta, int pokeAt);
    int c = 0;
    @(negedge clk);
    vstartIn = IW'(vs); vlIn = IW'(vl); totalIn = IW'(tot);
    vmIn = m; vmaIn = ma; vtaIn = ta; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (vs >= vl) begin
      cmpCycle("R1", vs, 1'b0, 0, 0, 1'b1, 0, 1'b0);
      @(negedge clk);
      chk("R1", "busy after early exit", longint'(busy), 0);
      chk("R1", "wrEn after early exit", longint'(wrEn), 0);
      return;
    end
    for (int i = vs; i < vl; i++) begin
      bit act = m | maskOf(i);
      string tg = m ? "R3" : (maskOf(i) ? "R4" : "R5");
      cmpCycle(tg, vs, act | ma, i, act ? longint'(opFn(i)) : ONES, 1'b0, i, !m);
      if (c == pokeAt) begin
        start = 1'b1; vstartIn = '0; vlIn = IW'(2); totalIn = IW'(2);
      end
      @(negedge clk);
      start = 1'b0;
      c++;
    end
    if (ta && tot > vl) begin
      for (int i = vl; i < tot; i++) begin
        cmpCycle("R6", vs, 1'b1, i, ONES, 1'b0, 0, 1'b0);
        @(negedge clk);
      end
    end
    cmpCycle("R9", vs, 1'b0, 0, 0, 1'b1, 0, 1'b0);
    @(negedge clk);
    chk("R10", "busy idle", longint'(busy), 0);
    chk("R9", "done idle", longint'(done), 0);
    chk("R6", "no write after done", longint'(wrEn), 0);
  endtask

  initial begin
    maskMem[0] = 64'hF0F0_1234_8000_00A5;
    maskMem[1] = 64'h0123_4567_89AB_CDEF;
    maskMem[2] = 64'h8000_0000_0000_0001;
    maskMem[3] = 64'h5555_AAAA_5555_AAAA;
    maskMem[4] = 64'hFFFF_0000_FFFF_0000;
    maskMem[5] = 64'h0;
    maskMem[6] = 64'hDEAD_BEEF_CAFE_F00D;
    maskMem[7] = 64'h1;
    // R11 reset state
    @(negedge clk);
    @(negedge clk);
    chk("R11", "busy", longint'(busy), 0);
    chk("R11", "done", longint'(done), 0);
    chk("R11", "wrEn", longint'(wrEn), 0);
    chk("R11", "vstartOut", longint'(vstartOut), 0);
    rstN = 1'b1;
    // R3 unmasked with tail fill (R6)
    runOp(0, 10, 16, 1'b1, 1'b0, 1'b1, -1);
    // R4/R5 masked, ones fill, tail skipped, crosses mask word
    runOp(2, 70, 80, 1'b0, 1'b1, 1'b0, -1);
    // R5 masked-off left unwritten, no tail since total == vl
    runOp(60, 130, 130, 1'b0, 1'b0, 1'b1, -1);
    // R1 early exits
    runOp(5, 5, 8, 1'b1, 1'b1, 1'b1, -1);
    runOp(9, 3, 8, 1'b0, 1'b1, 1'b1, -1);
    runOp(0, 0, 4, 1'b1, 1'b0, 1'b1, -1);
    // R10 start while busy ignored
    runOp(0, 8, 12, 1'b1, 1'b0, 1'b1, 3);
    // R7 prestart untouched, long tail up to top of range
    runOp(3, 4, 300, 1'b0, 1'b0, 1'b1, -1);
    runOp(200, 450, 511, 1'b0, 1'b1, 1'b1, 100);
    summary();
    $finish;
  end

endmodule